// File: doc/BRIEF.md
# Multiplier Contention Stall Controller

This block is the interlock for a single-issue, in-order pipeline in which one multiply-accumulate unit is shared by several instruction classes. Each cycle the decode stage presents one decoded instruction class and a valid flag. The block answers in the same cycle. It either lets the instruction enter execute or raises a stall that holds the instruction in decode.

A memory-operand multiply-accumulate takes three execution slots. The instruction behind it therefore waits two cycles whatever its class. The multiply-accumulate also keeps the multiplier locked for four cycles after it enters execute. A second multiply-accumulate may follow as soon as the execution slots are free, because its multiplier stages run straight on from the earlier ones. A plain multiply, or any move into or out of the multiply registers, must wait until the lock has cleared. The block also raises a one-cycle pulse in the cycle in which the accumulate result can be read. The multiplier datapath, operand fetch and register file lie outside the block. Only occupancy and timing are modelled.

Top module: `mac_interlock`

## Requirements
- R1: A synchronous active-high reset clears every hold, lock and pending result. In the first cycle after reset, a valid instruction of any class issues with no stall, and no result pulse appears.
- R2: When `in_valid` is low, both `stall` and `issue` are low.
- R3: `in_class` is encoded as 2'b00 other, 2'b01 memory-operand multiply-accumulate, 2'b10 plain multiply, 2'b11 multiply-register move or load. `issue` is high exactly when `in_valid` is high and `stall` is low.
- R4: For the EXEC_SLOTS-1 (default 2) cycles after a multiply-accumulate issues, every valid instruction stalls, whatever its class.
- R5: A multiply-accumulate that follows a multiply-accumulate issues EXEC_SLOTS (default 3) cycles after it, with no extra multiplier stall.
- R6: A plain multiply or multiply-register access stalls while fewer than LOCK_STATES+1 (default 5) cycles have passed since the last multiply-accumulate issued. Such an instruction issues 5 cycles after a multiply-accumulate at the earliest.
- R7: An instruction of class other never stalls on the multiplier lock. Once the execution slots are free (3 cycles after a multiply-accumulate), it issues.
- R8: `result_ready` is high for exactly one cycle, exactly LATENCY (default 5) cycles after each multiply-accumulate issues. There is one pulse per multiply-accumulate.
- R9: A multiply-accumulate that issues while the lock is active starts the lock again. After two multiply-accumulates 3 cycles apart, a plain multiply issues 5 cycles after the second one.
- R10: Plain multiplies and multiply-register accesses create neither a hold nor a lock. When no multiply-accumulate is in flight, such instructions issue on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The decode stage holds an instruction |
| in_class | input | 2 | Class of the instruction in decode (encoding in R3) |
| stall | output | 1 | Hold the instruction in decode this cycle |
| issue | output | 1 | The instruction enters execute this cycle |
| result_ready | output | 1 | One-cycle pulse: the accumulate result is readable |

## Verification
Two events can fall in the same cycle: a result pulse from an earlier multiply-accumulate, and the issue of a multiply-register read that was held by that multiply-accumulate's lock. Both fall exactly five cycles after the multiply-accumulate. The bench provokes this with a multiply-accumulate followed at once by a multiply or register move, then with long random streams. Its behavioural model predicts `stall`, `issue` and `result_ready` independently in every cycle. Stalled instructions stay at the head of the stream, so the measured issue gaps and the cycle of the pulse are judged against the cycle counts in the requirements.

// File: rtl/mac_interlock_pkg.sv
package mac_interlock_pkg;

    // Decoded instruction class seen by the interlock (R3)
    typedef enum logic [1:0] {
        CLS_OTHER = 2'b00,
        CLS_MAC   = 2'b01,
        CLS_MUL   = 2'b10,
        CLS_MREG  = 2'b11
    } instr_class_e;

    function automatic logic uses_mult_regs(input instr_class_e c);
        return (c == CLS_MUL) || (c == CLS_MREG);
    endfunction

endpackage

// File: rtl/mac_interlock_timer.sv
// Loadable down-counter: busy while non-zero, counts every cycle.
module mac_interlock_timer #(
    parameter int unsigned SPAN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int unsigned CW = (SPAN < 1) ? 1 : $clog2(SPAN + 1);

    generate
        if (SPAN == 0) begin : g_none
            logic unused_in;
            assign unused_in = clk ^ rst ^ load;
            assign busy = 1'b0;
        end else begin : g_count
            typedef struct packed {
                logic [CW-1:0] cnt;
            } tmr_state_t;

            tmr_state_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (load) begin
                    st_d.cnt = CW'(SPAN);
                end else if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign busy = (st_q.cnt != '0);
        end
    endgenerate
endmodule

// File: rtl/mac_interlock_delay.sv
// Fixed-depth pulse delay line; each tap is one register.
module mac_interlock_delay #(
    parameter int unsigned DEPTH = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic in_pulse,
    output logic out_pulse
);
    generate
        if (DEPTH == 0) begin : g_wire
            logic unused_in;
            assign unused_in = clk ^ rst;
            assign out_pulse = in_pulse;
        end else begin : g_taps
            typedef struct packed {
                logic [DEPTH-1:0] taps;
            } dly_state_t;

            dly_state_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                st_d.taps[0] = in_pulse;
                for (int i = 1; i < int'(DEPTH); i++) begin
                    st_d.taps[i] = st_q.taps[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign out_pulse = st_q.taps[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/mac_interlock_gate.sv
// Same-cycle issue decision from the hold and lock state.
module mac_interlock_gate
    import mac_interlock_pkg::*;
(
    input  logic       in_valid,
    input  logic [1:0] in_class,
    input  logic       hold_busy,
    input  logic       lock_busy,
    output logic       stall,
    output logic       issue,
    output logic       mac_issue
);
    instr_class_e cls;
    logic         lock_hit;

    always_comb begin
        cls       = instr_class_e'(in_class);
        // only classes that touch the multiply registers see the lock
        lock_hit  = lock_busy && uses_mult_regs(cls);
        stall     = in_valid && (hold_busy || lock_hit);
        issue     = in_valid && !stall;
        mac_issue = issue && (cls == CLS_MAC);
    end
endmodule

// File: rtl/mac_interlock.sv
module mac_interlock #(
    parameter int unsigned EXEC_SLOTS  = 3,
    parameter int unsigned LOCK_STATES = 4,
    parameter int unsigned LATENCY     = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [1:0] in_class,
    output logic       stall,
    output logic       issue,
    output logic       result_ready
);
    localparam int unsigned HOLD_SPAN = (EXEC_SLOTS > 0) ? EXEC_SLOTS - 1 : 0;

    logic hold_busy;
    logic lock_busy;
    logic mac_issue;

    mac_interlock_gate u_gate (
        .in_valid  (in_valid),
        .in_class  (in_class),
        .hold_busy (hold_busy),
        .lock_busy (lock_busy),
        .stall     (stall),
        .issue     (issue),
        .mac_issue (mac_issue)
    );

    // execution slots still held by the multiply-accumulate
    mac_interlock_timer #(.SPAN(HOLD_SPAN)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (mac_issue),
        .busy (hold_busy)
    );

    // multiplier lock, reloaded by every multiply-accumulate issue
    mac_interlock_timer #(.SPAN(LOCK_STATES)) u_lock (
        .clk  (clk),
        .rst  (rst),
        .load (mac_issue),
        .busy (lock_busy)
    );

    mac_interlock_delay #(.DEPTH(LATENCY)) u_result (
        .clk       (clk),
        .rst       (rst),
        .in_pulse  (mac_issue),
        .out_pulse (result_ready)
    );
endmodule

// File: rtl/mac_interlock_chk.sv
module mac_interlock_chk #(
    parameter int unsigned EXEC_SLOTS  = 3,
    parameter int unsigned LOCK_STATES = 4,
    parameter int unsigned LATENCY     = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [1:0] in_class,
    input logic       stall,
    input logic       issue,
    input logic       result_ready
);
    localparam int unsigned HOLD_SPAN = (EXEC_SLOTS > 0) ? EXEC_SLOTS - 1 : 0;
    localparam int unsigned CAP_A     = (LOCK_STATES > HOLD_SPAN) ? LOCK_STATES : HOLD_SPAN;
    localparam int unsigned CAP       = CAP_A + 1;
    localparam int unsigned SW        = $clog2(CAP + 1);
    localparam logic [SW-1:0] HOLD_L  = SW'(HOLD_SPAN);
    localparam logic [SW-1:0] LOCK_L  = SW'(LOCK_STATES);
    localparam logic [SW-1:0] CAP_L   = SW'(CAP);

    logic [SW-1:0] since_q;
    logic [7:0]    pend_q;
    logic          mac_go;
    logic          mult_cls;

    assign mac_go   = issue && (in_class == 2'b01);
    assign mult_cls = in_class[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
        end else if (mac_go) begin
            since_q <= SW'(1);
        end else if (since_q != '0 && since_q < CAP_L) begin
            since_q <= since_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_q + 8'(mac_go) - 8'(result_ready);
        end
    end

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !stall && !result_ready)
        else $error("R1 state after reset");

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !stall && !issue)
        else $error("R2 activity without valid");

    // R4
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && since_q != '0 && since_q <= HOLD_L) |-> stall)
        else $error("R4 instruction issued into busy slots");

    // R5
    mac_stream_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class == 2'b01 && (since_q == '0 || since_q > HOLD_L)) |-> !stall)
        else $error("R5 multiply-accumulate stalled on lock");

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mult_cls && since_q != '0 && since_q <= LOCK_L) |-> stall)
        else $error("R6 multiplier access during lock");

    // R7
    other_free_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class == 2'b00 && (since_q == '0 || since_q > HOLD_L)) |-> !stall)
        else $error("R7 other class stalled");

    // R10
    mult_free_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mult_cls && (since_q == '0 || since_q > LOCK_L)) |-> !stall)
        else $error("R10 multiply stalled with no lock");

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        result_ready |=> !result_ready)
        else $error("R8 result pulse wider than one cycle");

    // R8
    ready_owed_chk: assert property (@(posedge clk) disable iff (rst)
        result_ready |-> pend_q != '0)
        else $error("R8 result pulse without pending accumulate");
endmodule

bind mac_interlock mac_interlock_chk #(
    .EXEC_SLOTS  (EXEC_SLOTS),
    .LOCK_STATES (LOCK_STATES),
    .LATENCY     (LATENCY)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_class     (in_class),
    .stall        (stall),
    .issue        (issue),
    .result_ready (result_ready)
);

// File: tb/tb_mac_interlock.sv
`timescale 1ns/1ps
module tb_mac_interlock;
    localparam int EXEC_SLOTS  = 3;
    localparam int LOCK_STATES = 4;
    localparam int LATENCY     = 5;
    localparam int HOLD        = EXEC_SLOTS - 1;

    localparam logic [1:0] K_OTHER = 2'b00;
    localparam logic [1:0] K_MAC   = 2'b01;
    localparam logic [1:0] K_MUL   = 2'b10;
    localparam logic [1:0] K_MREG  = 2'b11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] in_class = 2'b00;
    logic       stall, issue, result_ready;

    always #2.5 clk = ~clk;

    mac_interlock #(
        .EXEC_SLOTS(EXEC_SLOTS), .LOCK_STATES(LOCK_STATES), .LATENCY(LATENCY)
    ) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .stall(stall), .issue(issue), .result_ready(result_ready)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_mac = -1000;
    int ready_at = -1;
    int rdy_q[$];
    logic [1:0] prog [8];
    int at_cyc [8];
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one cycle: drive, compare against the model, advance the model
    task automatic step(input logic v, input logic [1:0] c, output bit went);
        int d;
        bit hold, lock, mult, es, er;
        string tag;
        @(negedge clk);
        in_valid = v;
        in_class = c;
        #1;
        d    = cyc - last_mac;
        hold = (d >= 1 && d <= HOLD);
        lock = (d >= 1 && d <= LOCK_STATES);
        mult = (c == K_MUL || c == K_MREG);
        es   = v && (hold || (lock && mult));
        if (!v)                    tag = "R2";
        else if (hold)             tag = "R4";
        else if (lock && mult)     tag = "R6";
        else if (lock && c == K_MAC) tag = "R5";
        else if (lock)             tag = "R7";
        else if (mult)             tag = "R10";
        else                       tag = "R3";
        chk(tag, "stall", int'(stall), int'(es));
        chk(tag, "issue", int'(issue), int'(v && !es));
        er = (rdy_q.size() > 0) && (rdy_q[0] == cyc);
        if (er) void'(rdy_q.pop_front());
        chk("R8", "result_ready", int'(result_ready), int'(er));
        if (result_ready) ready_at = cyc;
        went = v && !es;
        if (went && c == K_MAC) begin
            last_mac = cyc;
            rdy_q.push_back(cyc + LATENCY);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        last_mac = -1000;
        rdy_q.delete();
    endtask

    task automatic run_prog(input int n);
        int idx = 0;
        int guard = 0;
        bit w;
        while (idx < n && guard < 60) begin
            step(1'b1, prog[idx], w);
            if (w) begin
                at_cyc[idx] = cyc;
                idx++;
            end
            guard++;
        end
        for (int k = 0; k < LATENCY + 2; k++) step(1'b0, K_OTHER, w);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit w;
        logic [1:0] cur;
        do_reset();
        // R1: quiet after reset, first instruction issues at once
        step(1'b0, K_OTHER, w);
        chk("R1", "stall idle", int'(stall), 0);
        chk("R1", "result_ready idle", int'(result_ready), 0);
        step(1'b1, K_MUL, w);
        chk("R1", "first issue", int'(issue), 1);
        step(1'b0, K_OTHER, w);

        // R5: streaming multiply-accumulates
        prog[0] = K_MAC; prog[1] = K_MAC;
        run_prog(2);
        chk("R5", "mac-mac gap", at_cyc[1] - at_cyc[0], EXEC_SLOTS);

        // R6 + R8: multiply after accumulate, issue and result pulse coincide
        prog[0] = K_MAC; prog[1] = K_MUL;
        run_prog(2);
        chk("R6", "mac-mul gap", at_cyc[1] - at_cyc[0], LOCK_STATES + 1);
        chk("R8", "ready cycle", ready_at, at_cyc[0] + LATENCY);

        prog[0] = K_MAC; prog[1] = K_MREG;
        run_prog(2);
        chk("R6", "mac-mreg gap", at_cyc[1] - at_cyc[0], LOCK_STATES + 1);

        // R7, R4: other waits only for the slots
        prog[0] = K_MAC; prog[1] = K_OTHER;
        run_prog(2);
        chk("R7", "mac-other gap", at_cyc[1] - at_cyc[0], EXEC_SLOTS);
        chk("R4", "slots held", at_cyc[1] - at_cyc[0] - 1, HOLD);

        // R9: second accumulate restarts the lock
        prog[0] = K_MAC; prog[1] = K_MAC; prog[2] = K_MREG;
        run_prog(3);
        chk("R9", "mac-mac gap", at_cyc[1] - at_cyc[0], EXEC_SLOTS);
        chk("R9", "second mac to mreg", at_cyc[2] - at_cyc[1], LOCK_STATES + 1);

        // R10: no lock from multiplies
        prog[0] = K_MUL; prog[1] = K_MUL; prog[2] = K_MREG; prog[3] = K_MUL;
        run_prog(4);
        chk("R10", "mul-mul gap", at_cyc[1] - at_cyc[0], 1);
        chk("R10", "mul-mreg gap", at_cyc[2] - at_cyc[1], 1);
        chk("R10", "mreg-mul gap", at_cyc[3] - at_cyc[2], 1);

        // R1: reset in the middle of a lock
        step(1'b1, K_MAC, w);
        do_reset();
        step(1'b1, K_MREG, w);
        chk("R1", "issue after mid-lock reset", int'(issue), 1);
        chk("R1", "no stale result", int'(result_ready), 0);

        // random streams, instruction held at head while stalled
        cur = 2'($urandom % 4);
        for (int n = 0; n < 4000; n++) begin
            bit v;
            v = ($urandom % 4) != 0;
            step(v, cur, w);
            if (w) cur = 2'($urandom % 4);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule